// File: doc/BRIEF.md
# Comma Word Aligner

This block frames a stream of 10-bit code groups whose word boundary is unknown. Each incoming raw word is joined with the word before it into a 20-bit window, with the older word in the low half because the earliest received bit is bit 0. All ten candidate boundaries are searched for the 7-bit comma prefix. When a search is armed and a comma is seen, the block captures that bit offset. From then on it emits every word cut from the window at that offset, until a new search is armed and finds a comma.

A search is armed by a rising edge on an asynchronous arm input. That input passes through three synchronizer flops before edge detection. Once an offset has been captured it stays frozen: a steady high arm level does not restart the search, and commas seen at other offsets are ignored. If the arm input falls before any comma arrives, the search is abandoned and the previous offset and lock state come back.

Both data sides use valid/ready handshakes. A raw word moves on a cycle where `raw_valid` and `raw_ready` are both high. `raw_ready` is high whenever the output register is empty or the downstream is taking its word (`out_ready`), so back-pressure passes straight through. A held output word does not change until it is taken.

Top module: `comma_word_aligner`

## Requirements
- R1: After reset, `locked` is 0, `out_valid` is 0, `raw_ready` is 1, and the frame offset is 0. Without any arming, words come out cut at offset 0.
- R2: Each accepted raw word produces exactly one output word on the next clock edge. That word is bits [off+9:off] of the window {new raw word, previous raw word}, where bit 0 is the earliest received bit.
- R3: A comma is a candidate word whose bits [6:0] equal 7'b1111100 (the negative-disparity form, bit 0 first) or its complement 7'b0000011. Both polarities arm a capture.
- R4: A rising edge on `arm_async` starts a search after three synchronizer stages. `locked` stays high through the third clock edge after the input rises and is low after the fourth.
- R5: During a search, the first accepted word whose window holds a comma captures that offset. If several offsets match, the lowest wins. The word carrying the comma is already output at the new offset, and `locked` rises on that same edge.
- R6: Outside a search, the offset never changes. Commas at other offsets are ignored, and a steady high `arm_async` does not start a new search.
- R7: If `arm_async` falls during a search before a comma arrives, the search ends after the synchronizer delay. The previous offset is kept and `locked` returns to its value before the search.
- R8: While `out_valid` is high and `out_ready` is low, `raw_ready` is 0 and `out_data` and `out_valid` hold. No raw word is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_async | input | 1 | Asynchronous search arm; a rising edge starts a comma search |
| raw_data | input | 10 | Unaligned raw word, earliest received bit in bit 0 |
| raw_valid | input | 1 | Raw word present |
| raw_ready | output | 1 | Aligner can take a raw word |
| out_data | output | 10 | Framed code group |
| out_valid | output | 1 | Framed word present |
| out_ready | input | 1 | Downstream takes the framed word |
| locked | output | 1 | An offset has been captured and no search is running |

## Verification
Bit streams of code groups are built with leading filler at several bit phases (0, 3, 7, 2, 4). Each one is fed either while a search is armed or while the offset is frozen, and the expected output is cut from the same bit stream at the offset the bench model predicts. A stream that needs a negative comma and one that needs a positive comma show that both polarities are matched. Streams sent with a comma at a different phase while locked, and after a cancelled search, show whether the frozen offset can be overwritten. Counting edges after the arm input rises pins down the synchronizer delay, and a stalled `out_ready` shows whether the held word and `raw_ready` behave under back-pressure.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
  localparam int CWA_COMMA_LEN = 7;
  // Comma prefix with the earliest received bit in bit 0 (negative disparity form).
  localparam logic [CWA_COMMA_LEN-1:0] CWA_COMMA_NEG = 7'b1111100;

  function automatic logic cwa_is_comma(input logic [CWA_COMMA_LEN-1:0] s);
    return (s == CWA_COMMA_NEG) || (s == ~CWA_COMMA_NEG);
  endfunction
endpackage

// File: rtl/cwa_arm_sync.sv
module cwa_arm_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_async,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], arm_async};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;
  assign fall = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/cwa_comma_scan.sv
module cwa_comma_scan #(
  parameter int W     = 10,
  parameter int OFF_W = $clog2(W)
) (
  input  logic [2*W-1:0]   win,
  output logic             hit,
  output logic [OFF_W-1:0] hit_off
);
  import cwa_pkg::*;

  logic [W-1:0] match;

  for (genvar k = 0; k < W; k++) begin : g_pos
    assign match[k] = cwa_is_comma(win[k +: CWA_COMMA_LEN]);
  end

  // Lowest matching offset wins.
  always_comb begin
    hit_off = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (match[k]) hit_off = OFF_W'(k);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/cwa_lock_ctrl.sv
module cwa_lock_ctrl #(
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic             accept,
  input  logic             hit,
  input  logic [OFF_W-1:0] hit_off,
  output logic             locked,
  output logic [OFF_W-1:0] use_off
);
  logic             searching_q;
  logic             have_q;
  logic [OFF_W-1:0] offset_q;
  logic             capture;

  assign capture = searching_q && !rise && !fall && accept && hit;
  assign use_off = capture ? hit_off : offset_q;
  assign locked  = have_q && !searching_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      searching_q <= 1'b0;
      have_q      <= 1'b0;
      offset_q    <= '0;
    end else if (capture) begin
      offset_q    <= hit_off;
      have_q      <= 1'b1;
      searching_q <= 1'b0;
    end else if (rise) begin
      searching_q <= 1'b1;
    end else if (fall) begin
      searching_q <= 1'b0;
    end
  end

  a_r4_rise_starts_search: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> searching_q);
  a_r6_offset_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !searching_q |=> $stable(offset_q));
  a_r5_lock_from_search: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(searching_q));
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int W           = 10,
  parameter int SYNC_STAGES = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm_async,
  input  logic [W-1:0] raw_data,
  input  logic         raw_valid,
  output logic         raw_ready,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         locked
);
  localparam int OFF_W = $clog2(W);

  logic             rise, fall, accept, hit;
  logic [OFF_W-1:0] hit_off, use_off;
  logic [W-1:0]     prev_q;
  logic [2*W-1:0]   win;

  assign raw_ready = !out_valid || out_ready;
  assign accept    = raw_valid && raw_ready;
  assign win       = {raw_data, prev_q};

  cwa_arm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .arm_async(arm_async), .rise(rise), .fall(fall));

  cwa_comma_scan #(.W(W), .OFF_W(OFF_W)) u_scan (
    .win(win), .hit(hit), .hit_off(hit_off));

  cwa_lock_ctrl #(.OFF_W(OFF_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .accept(accept),
    .hit(hit), .hit_off(hit_off), .locked(locked), .use_off(use_off));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else if (accept) begin
      prev_q    <= raw_data;
      out_data  <= win[use_off +: W];
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r2_accept_emits: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_valid && raw_ready) |=> out_valid);
endmodule

// File: tb/comma_word_aligner_tb_top.sv
module comma_word_aligner_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm_async = 1'b0;
  logic [9:0] raw_data = '0;
  logic       raw_valid = 1'b0;
  logic       raw_ready;
  logic [9:0] out_data;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       locked;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [9:0] codes [16];
  int         ncode;
  logic       stream_q [0:199];
  logic [9:0] last_raw;

  always #4 clk = ~clk;

  comma_word_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .arm_async(arm_async), .raw_data(raw_data),
    .raw_valid(raw_valid), .raw_ready(raw_ready), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .locked(locked));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Filler alternates 0/1 (never forms a comma); codes start at bit p.
  task automatic build(input int p);
    for (int i = 0; i < 200; i++) stream_q[i] = i[0];
    for (int j = 0; j < ncode; j++)
      for (int b = 0; b < 10; b++) stream_q[p + 10*j + b] = codes[j][b];
  endtask

  task automatic push(input logic [9:0] w);
    raw_data  = w;
    raw_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    raw_valid = 1'b0;
    last_raw  = w;
  endtask

  // cidx: index of the code expected to capture (-1: none).
  task automatic run_stream(input string tag, input int p, input int cidx,
                            input int old_off, input logic lock_before);
    build(p);
    for (int n = 0; n <= ncode; n++) begin
      logic [9:0] w;
      logic [9:0] exp;
      bit after;
      int eoff;
      for (int b = 0; b < 10; b++) w[b] = stream_q[10*n + b];
      push(w);
      if (n >= 1) begin
        after = (cidx >= 0) && (n - 1 >= cidx);
        eoff  = after ? p : old_off;
        for (int b = 0; b < 10; b++) exp[b] = stream_q[10*(n-1) + eoff + b];
        check({tag, " data"}, 32'(out_data), 32'(exp));
        check({tag, " locked"}, 32'(locked), 32'(after ? 1'b1 : lock_before));
        check("R2 out_valid after accept", 32'(out_valid), 32'd1);
      end
    end
  endtask

  task automatic t_reset;
    idle(1);
    check("R1 locked after reset", 32'(locked), 32'd0);
    check("R1 out_valid after reset", 32'(out_valid), 32'd0);
    check("R1 raw_ready after reset", 32'(raw_ready), 32'd1);
    codes[0] = 10'h155; codes[1] = 10'h2AA; codes[2] = 10'h0B9;
    codes[3] = 10'h17C; codes[4] = 10'h155; ncode = 5;
    run_stream("R1 unarmed offset 0", 0, -1, 0, 1'b0);
  endtask

  task automatic t_first_lock;
    arm_async = 1'b1; idle(6);
    check("R4 locked low while searching", 32'(locked), 32'd0);
    codes[0] = 10'h155; codes[1] = 10'h0B9; codes[2] = 10'h17C;
    codes[3] = 10'h2AA; codes[4] = 10'h0B9; codes[5] = 10'h155; ncode = 6;
    run_stream("R5 negative comma phase 3", 3, 2, 0, 1'b0);
  endtask

  task automatic t_pos_polarity;
    arm_async = 1'b0; idle(6);
    arm_async = 1'b1; idle(6);
    codes[0] = 10'h2AA; codes[1] = 10'h283; codes[2] = 10'h155;
    codes[3] = 10'h0B9; codes[4] = 10'h2AA; ncode = 5;
    run_stream("R3 positive comma phase 7", 7, 1, 3, 1'b0);
  endtask

  task automatic t_level_no_restart;
    codes[0] = 10'h155; codes[1] = 10'h17C; codes[2] = 10'h0B9;
    codes[3] = 10'h2AA; ncode = 4;
    run_stream("R6 level high comma at phase 2 ignored", 2, -1, 7, 1'b1);
  endtask

  task automatic t_sync_delay;
    arm_async = 1'b0; idle(6);
    check("R4 lock kept after arm falls while frozen", 32'(locked), 32'd1);
    arm_async = 1'b1;
    for (int e = 1; e <= 3; e++) begin
      @(negedge clk);
      check($sformatf("R4 locked at edge %0d", e), 32'(locked), 32'd1);
    end
    @(negedge clk);
    check("R4 locked low at edge 4", 32'(locked), 32'd0);
  endtask

  task automatic t_cancel;
    arm_async = 1'b0; idle(6);
    check("R7 lock restored after cancel", 32'(locked), 32'd1);
    codes[0] = 10'h155; codes[1] = 10'h17C; codes[2] = 10'h0B9;
    codes[3] = 10'h2AA; ncode = 4;
    run_stream("R7 old offset kept after cancel", 4, -1, 7, 1'b1);
  endtask

  task automatic t_backpressure;
    logic [9:0] held;
    logic [9:0] nw;
    logic [19:0] win;
    held = out_data;
    nw = 10'h3C5;
    out_ready = 1'b0;
    raw_data = nw; raw_valid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R8 raw_ready low when stalled", 32'(raw_ready), 32'd0);
      check("R8 out_data held when stalled", 32'(out_data), 32'(held));
      check("R8 out_valid held when stalled", 32'(out_valid), 32'd1);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    raw_valid = 1'b0;
    win = {nw, last_raw};
    last_raw = nw;
    check("R8 word taken after release", 32'(out_data), 32'(win[7 +: 10]));
    @(negedge clk);
    check("R8 out_valid clears when drained", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    last_raw = '0;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_lock();
    t_pos_polarity();
    t_level_no_restart();
    t_sync_delay();
    t_cancel();
    t_backpressure();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule